// File: doc/BRIEF.md
# Serial Command Frame Transmitter

This block is the sending half of a master on a two-wire serial link. The master drives the link clock, and the data wire is active low. A requester hands it one command: an absolute-address access (read or write), a data poll, or a terminate. The block assembles the command into a frame and adds a 4-bit check code. It sends a start bit, then the frame and the check code. It then drives the data wire high through an echo gap and releases the wire so that a slave can answer. Receiving the answer is left to other logic.

Each link bit takes two system clock cycles. The first is a low phase, in which the data wire may change. The second is a high phase, in which the data wire holds still. A request is taken in on a valid/ready handshake. While a frame is on the wire, ready stays low and any new request is ignored. A one-cycle done pulse marks the end of the echo gap, and ready returns in that same cycle.

Top module: `cmd_frame_tx`

## Requirements
- R1: Out of reset and whenever idle, the link clock is high, data out is high, the output enable is low, ready is high and done is low.
- R2: A request is accepted in a cycle where valid and ready are both high. Ready then stays low, and the output enable stays high, until the done cycle.
- R3: Each link bit lasts two cycles: the link clock is low for one cycle and then high for one cycle. Data out changes only when the link clock goes low. The first low phase is the cycle right after acceptance.
- R4: The first link bit is a start bit driven low. Every later frame and check bit is sent most significant first and is inverted on the wire (logical 1 goes out low).
- R5: An access frame (kind 00) holds, first to last: the 2-bit slave id, opcode 100, a direction bit (1 = read, 0 = write), 21 address bits, a size bit, the write data (writes only) and the check code.
- R6: Size code 0 means 1 byte: the address is sent unchanged and the size bit is 0. Size code 1 means 2 bytes: address bit 0 is sent as 0 and the size bit is 1. Size codes 2 and 3 mean 4 bytes: address bits 1:0 are sent as 01 and the size bit is 1.
- R7: Write data goes out byte 0 (wdata[7:0]) first, then byte 1, and so on. Only as many bytes as the size calls for are sent, each most significant bit first.
- R8: Kind 01 sends a data-poll frame: slave id, opcode 010, check code. Kinds 10 and 11 send a terminate frame: slave id, 6-bit opcode 111111, check code.
- R9: The check code is the remainder modulo x^4+x+1, starting from zero. It covers a leading logical 1 that stands for the start bit, followed by all frame bits. It is sent after the frame, bit 3 first.
- R10: After the check code, data out stays high with the output enable on for 16 link bits. Data out and the output enable are then released (data high, enable low).
- R11: Done pulses for exactly one cycle, 2*(21+N) cycles after the acceptance edge, where N is the number of frame bits.
- R12: A request presented while a frame is in progress is ignored: the frame on the wire is unchanged and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle and able to take a request |
| req_kind_i | input | 2 | 00 access, 01 data poll, 1x terminate |
| req_write_i | input | 1 | Access direction, 1 = write |
| req_slave_i | input | 2 | Slave id |
| req_addr_i | input | 21 | Access address |
| req_size_i | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| req_wdata_i | input | 32 | Write data, byte 0 in bits 7:0 |
| link_clk_o | output | 1 | Link clock |
| link_dat_o | output | 1 | Link data out |
| link_oe_o | output | 1 | Link data output enable |
| done_o | output | 1 | One-cycle pulse when the echo gap ends |

## Verification
Link bit k starts its low phase k*2 cycles after the acceptance edge, counting the start bit as k = 0, and its high phase one cycle later. Done is due 2*(21+N) cycles after that edge. The bench drives the request on a falling edge and takes the acceptance edge as the next rising edge. From then on it samples every output at each falling edge, so falling edge j sees bit j/2 in phase j%2, and the done cycle falls on edge 2T. Expected frame bits come from a bench-side field builder. The expected check code comes from polynomial long division.

// File: rtl/cmdtx_pkg.sv
package cmdtx_pkg;

  localparam int unsigned SLAVE_W  = 2;
  localparam int unsigned ADDR_W   = 21;
  localparam int unsigned DATA_B   = 4;
  localparam int unsigned CRC_W    = 4;
  localparam int unsigned FRAME_W  = 64;
  localparam int unsigned LEN_W    = $clog2(FRAME_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_FRAME, ST_CRC, ST_ECHO
  } tx_state_t;

  typedef struct packed {
    logic [FRAME_W-1:0] bits;   // left aligned, first bit at MSB
    logic [LEN_W-1:0]   len;
  } frame_t;

  // append the low w bits of v, most significant first
  function automatic frame_t push_field(frame_t f, logic [31:0] v, int unsigned w);
    frame_t r = f;
    for (int i = 31; i >= 0; i--) begin
      if (i < int'(w)) r.bits = {r.bits[FRAME_W-2:0], v[i]};
    end
    r.len = r.len + LEN_W'(w);
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] addr_adjust(logic [ADDR_W-1:0] a, logic [1:0] szc);
    logic [ADDR_W-1:0] r = a;
    if (szc == 2'd1)      r[0]   = 1'b0;
    else if (szc[1])      r[1:0] = 2'b01;
    return r;
  endfunction

  function automatic int unsigned size_bytes(logic [1:0] szc);
    return (szc == 2'd0) ? 1 : (szc == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [CRC_W-1:0] crc_step(logic [CRC_W-1:0] c, logic b);
    logic fb = b ^ c[CRC_W-1];
    return {c[CRC_W-2:0], 1'b0} ^ {2'b00, fb, fb};
  endfunction

  function automatic frame_t build_frame(logic [1:0] kind, logic wr, logic [SLAVE_W-1:0] slave,
                                         logic [ADDR_W-1:0] addr, logic [1:0] szc,
                                         logic [8*DATA_B-1:0] wdata);
    frame_t f = '0;
    f = push_field(f, 32'(slave), SLAVE_W);
    if (kind[1]) begin
      f = push_field(f, 32'h3f, 6);
    end else if (kind[0]) begin
      f = push_field(f, 32'b010, 3);
    end else begin
      f = push_field(f, 32'b100, 3);
      f = push_field(f, {31'b0, ~wr}, 1);
      f = push_field(f, 32'(addr_adjust(addr, szc)), ADDR_W);
      f = push_field(f, {31'b0, (szc != 2'd0)}, 1);
      if (wr) begin
        for (int b = 0; b < int'(DATA_B); b++) begin
          if (b < int'(size_bytes(szc))) f = push_field(f, 32'(wdata[8*b +: 8]), 8);
        end
      end
    end
    f.bits = f.bits << (FRAME_W - int'(f.len));
    return f;
  endfunction

endpackage

// File: rtl/cmdtx_frame_build.sv
module cmdtx_frame_build
  import cmdtx_pkg::*;
(
  input  logic [1:0]          kind_i,
  input  logic                write_i,
  input  logic [SLAVE_W-1:0]  slave_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [1:0]          size_i,
  input  logic [8*DATA_B-1:0] wdata_i,
  output frame_t              frame_o
);

  always_comb begin
    frame_o = build_frame(kind_i, write_i, slave_i, addr_i, size_i, wdata_i);
  end

endmodule

// File: rtl/cmdtx_crc4.sv
module cmdtx_crc4
  import cmdtx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed_i,   // absorb the implied start bit from zero
  input  logic             step_i,   // absorb one frame bit
  input  logic             bit_i,
  input  logic             shift_i,  // move next remainder bit to the top
  output logic [CRC_W-1:0] crc_o
);

  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       crc_q <= '0;
    else if (seed_i)  crc_q <= crc_step('0, 1'b1);
    else if (step_i)  crc_q <= crc_step(crc_q, bit_i);
    else if (shift_i) crc_q <= {crc_q[CRC_W-2:0], 1'b0};
  end

  assign crc_o = crc_q;

endmodule

// File: rtl/cmdtx_seq.sv
module cmdtx_seq
  import cmdtx_pkg::*;
#(
  parameter int unsigned ECHO_CLKS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  frame_t           frame_i,
  input  logic [CRC_W-1:0] crc_i,
  output logic             crc_seed_o,
  output logic             crc_step_o,
  output logic             crc_bit_o,
  output logic             crc_shift_o,
  output logic             link_clk_o,
  output logic             link_dat_o,
  output logic             link_oe_o,
  output logic             done_o,
  output tx_state_t        state_o
);

  localparam int unsigned ECHO_W = $clog2(ECHO_CLKS + 1);
  localparam int unsigned CNT_W  = (LEN_W > ECHO_W) ? LEN_W : ECHO_W;

  tx_state_t          state_q;
  logic               hi_next_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] shreg_q;
  logic               advance;
  logic               last;

  assign advance     = (state_q != ST_IDLE) && !hi_next_q;
  assign last        = (cnt_q == '0);
  assign crc_seed_o  = start_i;
  assign crc_bit_o   = shreg_q[FRAME_W-1];
  assign crc_step_o  = advance && ((state_q == ST_START) || (state_q == ST_FRAME && !last));
  assign crc_shift_o = advance && ((state_q == ST_FRAME && last) || (state_q == ST_CRC && !last));
  assign state_o     = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      hi_next_q  <= 1'b0;
      cnt_q      <= '0;
      shreg_q    <= '0;
      link_clk_o <= 1'b1;
      link_dat_o <= 1'b1;
      link_oe_o  <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (start_i) begin
          shreg_q    <= frame_i.bits;
          cnt_q      <= CNT_W'(frame_i.len) - CNT_W'(1);
          state_q    <= ST_START;
          link_clk_o <= 1'b0;
          link_dat_o <= 1'b0;
          link_oe_o  <= 1'b1;
          hi_next_q  <= 1'b1;
        end
      end else if (hi_next_q) begin
        link_clk_o <= 1'b1;
        hi_next_q  <= 1'b0;
      end else begin
        link_clk_o <= 1'b0;
        hi_next_q  <= 1'b1;
        unique case (state_q)
          ST_START: begin
            state_q    <= ST_FRAME;
            link_dat_o <= ~shreg_q[FRAME_W-1];
            shreg_q    <= shreg_q << 1;
          end
          ST_FRAME: begin
            if (last) begin
              state_q    <= ST_CRC;
              link_dat_o <= ~crc_i[CRC_W-1];
              cnt_q      <= CNT_W'(CRC_W - 1);
            end else begin
              link_dat_o <= ~shreg_q[FRAME_W-1];
              shreg_q    <= shreg_q << 1;
              cnt_q      <= cnt_q - CNT_W'(1);
            end
          end
          ST_CRC: begin
            if (last) begin
              state_q    <= ST_ECHO;
              link_dat_o <= 1'b1;
              cnt_q      <= CNT_W'(ECHO_CLKS - 1);
            end else begin
              link_dat_o <= ~crc_i[CRC_W-1];
              cnt_q      <= cnt_q - CNT_W'(1);
            end
          end
          ST_ECHO: begin
            link_dat_o <= 1'b1;
            if (last) begin
              state_q    <= ST_IDLE;
              link_clk_o <= 1'b1;
              hi_next_q  <= 1'b0;
              link_oe_o  <= 1'b0;
              done_o     <= 1'b1;
            end else begin
              cnt_q <= cnt_q - CNT_W'(1);
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/cmd_frame_tx.sv
module cmd_frame_tx
  import cmdtx_pkg::*;
#(
  parameter int unsigned ECHO_CLKS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [1:0]          req_kind_i,
  input  logic                req_write_i,
  input  logic [SLAVE_W-1:0]  req_slave_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [1:0]          req_size_i,
  input  logic [8*DATA_B-1:0] req_wdata_i,
  output logic                link_clk_o,
  output logic                link_dat_o,
  output logic                link_oe_o,
  output logic                done_o
);

  frame_t           frame_w;
  logic [CRC_W-1:0] crc_w;
  logic             accept_w;
  logic             crc_seed_w, crc_step_w, crc_bit_w, crc_shift_w;
  tx_state_t        state_w;
  logic             in_echo_w;

  assign accept_w    = req_valid_i && req_ready_o;
  assign req_ready_o = (state_w == ST_IDLE);
  assign in_echo_w   = (state_w == ST_ECHO);

  cmdtx_frame_build build_i (
    .kind_i  (req_kind_i),
    .write_i (req_write_i),
    .slave_i (req_slave_i),
    .addr_i  (req_addr_i),
    .size_i  (req_size_i),
    .wdata_i (req_wdata_i),
    .frame_o (frame_w)
  );

  cmdtx_crc4 crc_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .seed_i  (crc_seed_w),
    .step_i  (crc_step_w),
    .bit_i   (crc_bit_w),
    .shift_i (crc_shift_w),
    .crc_o   (crc_w)
  );

  cmdtx_seq #(.ECHO_CLKS(ECHO_CLKS)) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (accept_w),
    .frame_i     (frame_w),
    .crc_i       (crc_w),
    .crc_seed_o  (crc_seed_w),
    .crc_step_o  (crc_step_w),
    .crc_bit_o   (crc_bit_w),
    .crc_shift_o (crc_shift_w),
    .link_clk_o  (link_clk_o),
    .link_dat_o  (link_dat_o),
    .link_oe_o   (link_oe_o),
    .done_o      (done_o),
    .state_o     (state_w)
  );

endmodule

// File: rtl/cmd_frame_tx_chk.sv
module cmd_frame_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid_i,
  input logic       req_ready_o,
  input logic       link_clk_o,
  input logic       link_dat_o,
  input logic       link_oe_o,
  input logic       done_o,
  input logic       in_echo_w,
  input logic [3:0] crc_w
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready_o |-> (link_clk_o && link_dat_o && !link_oe_o));

  p_busy_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready_o |-> link_oe_o);

  p_low_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !link_clk_o |=> link_clk_o);

  p_stable_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    link_clk_o |-> $stable(link_dat_o));

  p_start_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o) |=> (!link_clk_o && !link_dat_o && link_oe_o));

  p_crc_seed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o) |=> (crc_w == 4'b0011));

  p_echo_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_echo_w |-> (link_dat_o && link_oe_o));

  p_done_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!link_oe_o && link_dat_o && req_ready_o));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

bind cmd_frame_tx cmd_frame_tx_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .link_clk_o  (link_clk_o),
  .link_dat_o  (link_dat_o),
  .link_oe_o   (link_oe_o),
  .done_o      (done_o),
  .in_echo_w   (in_echo_w),
  .crc_w       (crc_w)
);

// File: tb/cmd_frame_tx_tb_top.sv
module cmd_frame_tx_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_kind;
  logic        req_write;
  logic [1:0]  req_slave;
  logic [20:0] req_addr;
  logic [1:0]  req_size;
  logic [31:0] req_wdata;
  logic        link_clk, link_dat, link_oe, done;

  always #5 clk = ~clk;

  cmd_frame_tx dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_kind_i(req_kind), .req_write_i(req_write), .req_slave_i(req_slave),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_wdata_i(req_wdata),
    .link_clk_o(link_clk), .link_dat_o(link_dat), .link_oe_o(link_oe), .done_o(done)
  );

  int   errors = 0;
  int   checks = 0;
  logic exp_frame [0:63];
  int   exp_n;
  logic [3:0] exp_crc;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] v, input int w);
    for (int i = w - 1; i >= 0; i--) begin
      exp_frame[exp_n] = v[i];
      exp_n++;
    end
  endtask

  // bench view of the frame layout (R5..R8)
  task automatic build_exp(input logic [1:0] kind, input logic wr, input logic [1:0] slave,
                           input logic [20:0] addr, input logic [1:0] szc, input logic [31:0] wd);
    logic [20:0] a;
    int nb;
    exp_n = 0;
    push(32'(slave), 2);
    case (kind)
      2'b01: push(32'h2, 3);
      2'b10, 2'b11: push(32'h3f, 6);
      default: begin
        push(32'h4, 3);
        push(wr ? 32'd0 : 32'd1, 1);
        if (szc == 2'd0)      begin a = addr;                  nb = 1; end
        else if (szc == 2'd1) begin a = {addr[20:1], 1'b0};    nb = 2; end
        else                  begin a = {addr[20:2], 2'b01};   nb = 4; end
        push(32'(a), 21);
        push((szc == 2'd0) ? 32'd0 : 32'd1, 1);
        if (wr) for (int b = 0; b < nb; b++) push(32'((wd >> (8 * b)) & 32'hff), 8);
      end
    endcase
  endtask

  // remainder by long division over {1, frame, 0000} with divisor 10011 (R9)
  task automatic calc_crc();
    logic m [0:72];
    logic [4:0] dv = 5'b10011;
    m[0] = 1'b1;
    for (int i = 0; i < exp_n; i++) m[i + 1] = exp_frame[i];
    for (int i = 0; i < 4; i++) m[exp_n + 1 + i] = 1'b0;
    for (int i = 0; i <= exp_n; i++) begin
      if (m[i]) for (int k = 0; k < 5; k++) m[i + k] = m[i + k] ^ dv[4 - k];
    end
    for (int k = 0; k < 4; k++) exp_crc[3 - k] = m[exp_n + 1 + k];
  endtask

  function automatic logic wire_bit(int idx);
    if (idx == 0) return 1'b0;
    if (idx <= exp_n) return ~exp_frame[idx - 1];
    if (idx <= exp_n + 4) return ~exp_crc[3 - (idx - exp_n - 1)];
    return 1'b1;
  endfunction

  task automatic run_xfer(input logic [1:0] kind, input logic wr, input logic [1:0] slave,
                          input logic [20:0] addr, input logic [1:0] szc, input logic [31:0] wd,
                          input string tag, input bit intrude);
    int t, e_clk, e_oe, e_rdy, e_start, e_frame, e_crc, e_echo, bi;
    @(negedge clk);
    req_kind = kind; req_write = wr; req_slave = slave;
    req_addr = addr; req_size = szc; req_wdata = wd;
    req_valid = 1'b1;
    chk(req_ready == 1'b1, "R2", "ready before request", req_ready, 1);
    build_exp(kind, wr, slave, addr, szc, wd);
    calc_crc();
    t = 1 + exp_n + 4 + 16;
    @(negedge clk);
    req_valid = 1'b0;
    e_clk = 0; e_oe = 0; e_rdy = 0; e_start = 0; e_frame = 0; e_crc = 0; e_echo = 0;
    for (int j = 0; j < 2 * t; j++) begin
      bi = j / 2;
      if (link_clk !== logic'(j % 2)) e_clk++;
      if (link_oe !== 1'b1) e_oe++;
      if (req_ready !== 1'b0 || done !== 1'b0) e_rdy++;
      if (link_dat !== wire_bit(bi)) begin
        if (bi == 0) e_start++;
        else if (bi <= exp_n) e_frame++;
        else if (bi <= exp_n + 4) e_crc++;
        else e_echo++;
      end
      if (intrude && j == 6) begin
        req_valid = 1'b1; req_kind = ~kind; req_addr = ~addr; req_slave = ~slave; req_write = ~wr;
      end
      if (intrude && j == 7) req_valid = 1'b0;
      @(negedge clk);
    end
    chk(e_clk == 0, "R3", "link clock low/high pattern mismatches", e_clk, 0);
    chk(e_rdy == 0, "R2", "ready or done seen during transfer", e_rdy, 0);
    chk(e_oe == 0, "R2", "output enable dropped during transfer", e_oe, 0);
    chk(e_start == 0, "R4", "start bit mismatches", e_start, 0);
    chk(e_frame == 0, tag, "frame bit mismatches", e_frame, 0);
    chk(e_crc == 0, "R9", "check code bit mismatches", e_crc, 0);
    chk(e_echo == 0, "R10", "echo gap bit mismatches", e_echo, 0);
    if (intrude)
      chk((e_frame + e_crc + e_start) == 0, "R12", "frame disturbed by request while busy",
          e_frame + e_crc + e_start, 0);
    chk(done === 1'b1, "R11", "done at cycle 2T after accept", done, 1);
    chk(link_oe === 1'b0 && link_dat === 1'b1 && req_ready === 1'b1, "R10",
        "line released with done", {link_oe, link_dat, req_ready}, 3'b011);
    @(negedge clk);
    chk(done === 1'b0, "R11", "done lasts one cycle", done, 0);
    chk(link_clk === 1'b1 && link_oe === 1'b0, "R12", "no frame follows",
        {link_clk, link_oe}, 2'b10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R11 watchdog expired: actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [1:0] k;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'b00; req_write = 1'b0;
    req_slave = 2'b00; req_addr = '0; req_size = 2'b00; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(link_clk === 1'b1 && link_dat === 1'b1 && link_oe === 1'b0, "R1",
        "idle line after reset", {link_clk, link_dat, link_oe}, 3'b110);
    chk(req_ready === 1'b1 && done === 1'b0, "R1", "idle handshake after reset",
        {req_ready, done}, 2'b10);

    run_xfer(2'b00, 1'b0, 2'd1, 21'h12345, 2'd0, 32'h0,        "R5", 1'b0);
    run_xfer(2'b00, 1'b0, 2'd2, 21'h0abcd, 2'd1, 32'h0,        "R6", 1'b0);
    run_xfer(2'b00, 1'b0, 2'd3, 21'h1fffe, 2'd2, 32'h0,        "R6", 1'b0);
    run_xfer(2'b00, 1'b1, 2'd0, 21'h00003, 2'd3, 32'h55aa00ff, "R6", 1'b0);
    run_xfer(2'b00, 1'b1, 2'd1, 21'h1ffff, 2'd1, 32'hdead1234, "R6", 1'b0);
    run_xfer(2'b00, 1'b1, 2'd2, 21'h00010, 2'd0, 32'h000000a5, "R7", 1'b0);
    run_xfer(2'b00, 1'b1, 2'd3, 21'h00400, 2'd2, 32'h11223344, "R7", 1'b0);
    run_xfer(2'b01, 1'b0, 2'd2, 21'h0,     2'd0, 32'h0,        "R8", 1'b0);
    run_xfer(2'b10, 1'b0, 2'd1, 21'h0,     2'd0, 32'h0,        "R8", 1'b0);
    run_xfer(2'b11, 1'b1, 2'd3, 21'h0,     2'd0, 32'h0,        "R8", 1'b0);
    run_xfer(2'b00, 1'b1, 2'd1, 21'h0c0de, 2'd2, 32'hcafef00d, "R5", 1'b1);

    for (int n = 0; n < 25; n++) begin
      k = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 1) == 1) k = 2'b00;
      run_xfer(k, 1'($urandom), 2'($urandom), 21'($urandom), 2'($urandom), $urandom,
               (k == 2'b00) ? "R5" : "R8", (n % 5) == 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule